// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a single memory-mapped timer. A free-running up-counter advances on every clock cycle in which the count-enable input is high and the run bit is set. The counter is compared against a programmable match value. The first cycle in which the two are equal while the timer runs produces a one-cycle interrupt pulse. Software uses this pulse as a rising edge.

A control bit can make the counter restart from zero after a match, which turns the block into a periodic tick source. A dedicated register zeroes the counter whenever it is written. A lock bit freezes the match, control and zeroing registers so that stray writes cannot disturb a running schedule. All registers sit on a plain 32-bit write/read bus that uses byte offsets. Reads are combinational, so the live count can be sampled at any time, including while the match value is being changed.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count reads 0, the control register reads 0, the lock register reads 0, the match register reads all ones (over the counter width), and `irq_out` is low.
- R2: The count increases by one on each clock edge where `tick` is 1 and control bit 0 (run) is 1. In every other case it holds its value, unless R5 or R6 applies.
- R3: The count wraps from its all-ones value to 0 and keeps counting.
- R4: `irq_out` is high for exactly one cycle: the cycle after the first cycle in which run is 1 and the count equals the match value. It does not pulse again while that equality persists.
- R5: When control bit 1 (auto-restart) is set, a counting edge at which the count equals the match value loads 0 instead of incrementing.
- R6: A write of any data to offset 0x0C zeroes the count at the next edge. This takes priority over counting.
- R7: While bit 0 of offset 0x20 (lock) is 1, writes to offsets 0x00, 0x08 and 0x0C have no effect. Offset 0x20 itself always remains writable.
- R8: Reads return, in the same cycle, the match value at 0x00, the live count at 0x04, the run and auto-restart bits in bits 0 and 1 at 0x08, and the lock bit in bit 0 at 0x20. All unused bits read as zero.
- R9: Writes to offset 0x04 and to unmapped offsets change no register. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; advances the counter when high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | One-cycle expiry pulse |

## Verification
The hardest situation to reach from the ports is the counter wrap. The count register cannot be written, so the only way to reach the all-ones value is to count through the entire range. For this reason the bench builds the block with a 10-bit counter and runs a long stretch with `tick` held high, so the count passes its top value and continues from zero. The random phase picks match values close to the model's current count. This makes matches, auto-restart edges and repeated-equality cases with `tick` low occur often rather than by chance.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/1ps
package cmp_timer_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_MATCH = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_ZERO  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_LOCK  = 6'h20;

    localparam int BIT_RUN     = 0;
    localparam int BIT_RESTART = 1;
endpackage

// File: rtl/cmp_timer_regs.sv
`timescale 1ns/1ps
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  match_o,
    output logic              run_o,
    output logic              restart_o,
    output logic              lock_o,
    output logic              zero_o
);
    typedef struct packed {
        logic [CNT_W-1:0] match;
        logic             run;
        logic             restart;
        logic             lock;
    } regs_t;

    regs_t reg_d, reg_q;

    always_comb begin
        reg_d  = reg_q;
        zero_o = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                OFF_LOCK:  reg_d.lock = bus_wdata[0];
                OFF_MATCH: if (!reg_q.lock) reg_d.match = bus_wdata[CNT_W-1:0];
                OFF_CTRL: begin
                    if (!reg_q.lock) begin
                        reg_d.run     = bus_wdata[BIT_RUN];
                        reg_d.restart = bus_wdata[BIT_RESTART];
                    end
                end
                OFF_ZERO:  zero_o = !reg_q.lock;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q.match   <= '1;
            reg_q.run     <= 1'b0;
            reg_q.restart <= 1'b0;
            reg_q.lock    <= 1'b0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign match_o   = reg_q.match;
    assign run_o     = reg_q.run;
    assign restart_o = reg_q.restart;
    assign lock_o    = reg_q.lock;

    // R7: locked writes leave the match and control state untouched
    a_r7_match_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.lock && bus_wr && bus_addr == OFF_MATCH) |=> $stable(match_o));
    a_r7_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.lock && bus_wr && bus_addr == OFF_CTRL) |=> ($stable(run_o) && $stable(restart_o)));
    // R9: a write to the count offset changes no register
    a_r9_count_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_COUNT) |=> ($stable(match_o) && $stable(lock_o) && $stable(run_o)));
endmodule

// File: rtl/cmp_timer_counter.sv
`timescale 1ns/1ps
module cmp_timer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             restart,
    input  logic             zero,
    input  logic [CNT_W-1:0] match,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             eq_prev;
        logic             irq;
    } cnt_t;

    cnt_t st_d, st_q;
    logic hit;

    always_comb begin
        st_d         = st_q;
        hit          = run && (st_q.cnt == match);
        st_d.eq_prev = hit;
        st_d.irq     = hit && !st_q.eq_prev;
        if (zero) begin
            st_d.cnt = '0;
        end else if (run && tick) begin
            st_d.cnt = (restart && hit) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign irq_o   = st_q.irq;

    // R2: without an advance or zeroing the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick) && !zero) |=> $stable(count_o));
    // R3: the top value rolls over to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !zero && !restart && count_o == '1) |=> (count_o == '0));
    // R4: the interrupt never lasts two cycles
    a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R5: auto-restart returns to zero on a counting match
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && restart && count_o == match) |=> (count_o == '0));
    // R6: zeroing write wins over counting
    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero |=> (count_o == '0));
endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic [CNT_W-1:0] match_w, count_w;
    logic             run_w, restart_w, lock_w, zero_w;

    cmp_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .match_o   (match_w),
        .run_o     (run_w),
        .restart_o (restart_w),
        .lock_o    (lock_w),
        .zero_o    (zero_w)
    );

    cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run_w),
        .restart (restart_w),
        .zero    (zero_w),
        .match   (match_w),
        .count_o (count_w),
        .irq_o   (irq_out)
    );

    always_comb begin
        case (bus_addr)
            OFF_MATCH: bus_rdata = DATA_W'(match_w);
            OFF_COUNT: bus_rdata = DATA_W'(count_w);
            OFF_CTRL:  bus_rdata = DATA_W'({restart_w, run_w});
            OFF_LOCK:  bus_rdata = DATA_W'(lock_w);
            default:   bus_rdata = '0;
        endcase
    end

    // R1: interrupt is quiet in the cycle after reset
    a_r1_irq_reset: assert property (@(posedge clk)
        !rst_n |=> !irq_out);
endmodule

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
    localparam int W = 10;
    localparam logic [31:0] MASK = (32'd1 << W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = 6'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_cnt, m_match;
    bit m_run, m_rst, m_lock, m_eqp, m_irq;

    always #5 clk = ~clk;

    cmp_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00: return m_match;
            6'h04: return m_cnt;
            6'h08: return {30'd0, m_rst, m_run};
            6'h20: return {31'd0, m_lock};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step(input bit wr, input logic [5:0] a, input logic [31:0] d, input bit tk);
        bit hit;
        hit = m_run && (m_cnt == m_match);
        m_irq = hit && !m_eqp;
        m_eqp = hit;
        if (wr && a == 6'h0C && !m_lock) m_cnt = 0;
        else if (m_run && tk) m_cnt = (m_rst && hit) ? 0 : ((m_cnt + 1) & MASK);
        if (wr) begin
            if (a == 6'h20) m_lock = d[0];
            else if (!m_lock && a == 6'h00) m_match = d & MASK;
            else if (!m_lock && a == 6'h08) begin m_run = d[0]; m_rst = d[1]; end
        end
    endtask

    // one cycle: check a read and the interrupt, then drive and advance
    task automatic cyc(input bit wr, input logic [5:0] a, input logic [31:0] d,
                       input bit tk, input logic [5:0] ra, input string tag);
        bus_wr = 1'b0; bus_addr = ra; #1;
        check(tag, bus_rdata, exp_read(ra));
        check("R4", {31'd0, irq_out}, {31'd0, m_irq});
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk;
        model_step(wr, a, d, tk);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit tk, input logic [5:0] ra, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 6'h00, 32'h0, tk, ra, tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] seed;
        m_cnt = 0; m_match = MASK; m_run = 0; m_rst = 0; m_lock = 0; m_eqp = 0; m_irq = 0;
        seed = $urandom(32'd4711);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        cyc(0, 0, 0, 1, 6'h00, "R1");
        cyc(0, 0, 0, 1, 6'h04, "R1");
        cyc(0, 0, 0, 1, 6'h08, "R1");
        cyc(0, 0, 0, 1, 6'h20, "R1");
        // R8: readback of match and control
        cyc(1, 6'h00, 32'h5, 1, 6'h04, "R2");
        cyc(1, 6'h08, 32'h1, 1, 6'h00, "R8");
        cyc(0, 0, 0, 1, 6'h08, "R8");
        // R2/R4: count to and past the match
        idle(10, 1, 6'h04, "R2");
        // R2: no advance without tick
        idle(4, 0, 6'h04, "R2");
        // R6: zeroing write, any data
        cyc(1, 6'h0C, 32'hDEAD_BEEF, 1, 6'h04, "R6");
        cyc(0, 0, 0, 1, 6'h04, "R6");
        // R5: auto-restart period
        cyc(1, 6'h00, 32'h3, 1, 6'h04, "R5");
        cyc(1, 6'h08, 32'h3, 1, 6'h04, "R5");
        idle(12, 1, 6'h04, "R5");
        idle(3, 0, 6'h04, "R5");
        // R7: lock blocks match, control and zeroing
        cyc(1, 6'h20, 32'h1, 1, 6'h20, "R7");
        cyc(1, 6'h00, 32'h7, 1, 6'h20, "R7");
        cyc(1, 6'h08, 32'h0, 1, 6'h00, "R7");
        cyc(1, 6'h0C, 32'h0, 1, 6'h08, "R7");
        cyc(0, 0, 0, 1, 6'h04, "R7");
        cyc(1, 6'h20, 32'h0, 1, 6'h04, "R7");
        cyc(0, 0, 0, 1, 6'h20, "R7");
        // R9: count offset and unmapped offsets are not writable
        cyc(1, 6'h04, 32'h55, 1, 6'h04, "R9");
        cyc(1, 6'h10, 32'hFFFF_FFFF, 1, 6'h04, "R9");
        cyc(0, 0, 0, 1, 6'h10, "R9");
        cyc(0, 0, 0, 1, 6'h00, "R9");
        // R3: free run through the top value
        cyc(1, 6'h08, 32'h1, 1, 6'h04, "R3");
        cyc(1, 6'h00, 32'h2, 1, 6'h04, "R3");
        cyc(1, 6'h0C, 32'h0, 1, 6'h04, "R3");
        idle(1100, 1, 6'h04, "R3");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit wr, tk;
            logic [5:0] a, ra;
            logic [31:0] d;
            logic [5:0] offs[7];
            offs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h20, 6'h10, 6'h3C};
            tk = ($urandom % 4) != 0;
            wr = ($urandom % 8) == 0;
            a = offs[$urandom % 7];
            d = $urandom;
            if (a == 6'h00) d = (m_cnt + ($urandom % 6)) & MASK;
            if (a == 6'h08) d = {30'd0, 1'($urandom % 2), 1'(($urandom % 5) != 0)};
            if (a == 6'h20) d = {31'd0, 1'(($urandom % 3) == 0)};
            ra = offs[$urandom % 7];
            cyc(wr, a, d, tk, ra, (ra == 6'h04) ? "R2" : "R8");
        end
        summary();
    end
endmodule